// File: doc/BRIEF.md
# External Interrupt Flag Controller

This block watches eight external interrupt request pins. Each pin has its own status flag and its own sense mode. The mode is chosen by two select bits per channel: one bit in an upper select register and one in a lower select register. Depending on the mode, a flag is raised by a low input level, by a falling edge, by a rising edge, or by either edge. Each raw pin passes through a synchroniser before the sense logic sees it. Edges are found by comparing the newest synchronised sample with the one taken a cycle earlier.

Flags are cleared in two ways. Software can clear a flag through a handshake: it first reads the bit as 1, then writes 0 to it. The interrupt controller can also clear a flag with an acknowledge strobe, which names the channel whose exception handling has started. Four hold inputs can keep a flag set through an acknowledge, for channels 4 to 7. A per-channel enable register selects which flags feed the combined request output.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, all flags, both select registers, the enable register and `irq_req` are 0.
- R2: Register map on `bus_addr`: 0 holds the flags, 1 holds the upper select bits, 2 holds the lower select bits, 3 holds the request enables. Select and enable registers read back what was last written. The sense mode of channel i is {upper[i], lower[i]}: 00 is low level, 01 is falling edge, 10 is rising edge, 11 is both edges.
- R3: In low-level mode, a flag is set while its synchronised input is low. The flag reads 1 on the third rising clock edge after the pin changes.
- R4: In falling-edge mode, only a high-to-low transition sets the flag. A low-to-high transition leaves it clear.
- R5: In rising-edge mode, only a low-to-high transition sets the flag. A high-to-low transition leaves it clear.
- R6: In both-edge mode, either transition sets the flag.
- R7: A write of 0 to a flag bit clears it only if that bit was read as 1 since the previous write to the flag register. A write of 1, or a write of 0 with no such read, leaves the flag unchanged. Every write to the flag register uses up the read history of all bits.
- R8: An acknowledge for a channel in any edge mode clears that channel's flag on the next clock edge.
- R9: An acknowledge for a channel in low-level mode clears the flag only if the synchronised input is high. While the input is low, the flag stays set.
- R10: While `xfer_hold[k]` is 1, an acknowledge does not clear the flag of channel 4+k. The software handshake still clears it.
- R11: When a set condition and a clear fall in the same cycle, the flag ends up set.
- R12: `irq_req` is 1 exactly when at least one flag is set whose enable bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 8 | Raw external interrupt pins |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| ack_valid | input | 1 | Interrupt acknowledge strobe |
| ack_chan | input | 3 | Channel being acknowledged |
| xfer_hold | input | 4 | Suppress acknowledge clear for channels 4 to 7 |
| flag_o | output | 8 | Per-channel flags |
| irq_req | output | 1 | OR of enabled flags |

## Verification
The bench builds the block with its default parameters: eight channels, a two-stage synchroniser and four hold inputs starting at channel 4. With these values, every sense mode can be placed on a different channel at once. The three-cycle pin-to-flag latency can be counted exactly, and the hold inputs can be set on a channel that also takes acknowledges. The bench also lines up a set condition and a handshake clear in the same cycle to check which one wins.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_FALL = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;

  typedef enum logic [1:0] {
    RA_FLAG  = 2'd0,
    RA_SELHI = 2'd1,
    RA_SELLO = 2'd2,
    RA_ENA   = 2'd3
  } reg_addr_e;

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int NCH    = 8,
  parameter int STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pin_i,
  output logic [NCH-1:0] lvl_o,
  output logic [NCH-1:0] prev_o
);

  localparam int LAST = STAGES - 1;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;
    logic              prev_q;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], pin_i[c]};
    end

    // Idle level is high, so the chain resets to 1 and no low or edge is seen after reset.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '1;
        prev_q  <= 1'b1;
      end else begin
        chain_q <= chain_d;
        prev_q  <= chain_q[LAST];
      end
    end

    assign lvl_o[c]  = chain_q[LAST];
    assign prev_o[c] = prev_q;
  end

endmodule

// File: rtl/irq_host_regs.sv
module irq_host_regs
  import irq_flag_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rd_i,
  input  logic           wr_i,
  input  logic [1:0]     addr_i,
  input  logic [NCH-1:0] wdata_i,
  input  logic [NCH-1:0] flag_i,
  output logic [NCH-1:0] rdata_o,
  output logic [NCH-1:0] selhi_o,
  output logic [NCH-1:0] sello_o,
  output logic [NCH-1:0] ena_o,
  output logic [NCH-1:0] wclr_o
);

  logic [NCH-1:0] selhi_q, sello_q, ena_q, arm_q;
  logic [NCH-1:0] arm_d;
  logic           wr_flag, rd_flag, wr_hi, wr_lo, wr_en, arm_en;

  always_comb begin
    wr_flag = wr_i && (reg_addr_e'(addr_i) == RA_FLAG);
    rd_flag = rd_i && (reg_addr_e'(addr_i) == RA_FLAG);
    wr_hi   = wr_i && (reg_addr_e'(addr_i) == RA_SELHI);
    wr_lo   = wr_i && (reg_addr_e'(addr_i) == RA_SELLO);
    wr_en   = wr_i && (reg_addr_e'(addr_i) == RA_ENA);
    arm_en  = wr_flag || rd_flag;
    if (wr_flag) arm_d = '0;
    else         arm_d = arm_q | flag_i;
    wclr_o = wr_flag ? (arm_q & ~wdata_i) : '0;
  end

  always_comb begin
    unique case (reg_addr_e'(addr_i))
      RA_FLAG:  rdata_o = flag_i;
      RA_SELHI: rdata_o = selhi_q;
      RA_SELLO: rdata_o = sello_q;
      default:  rdata_o = ena_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      selhi_q <= '0;
      sello_q <= '0;
      ena_q   <= '0;
      arm_q   <= '0;
    end else begin
      if (wr_hi)  selhi_q <= wdata_i;
      if (wr_lo)  sello_q <= wdata_i;
      if (wr_en)  ena_q   <= wdata_i;
      if (arm_en) arm_q   <= arm_d;
    end
  end

  assign selhi_o = selhi_q;
  assign sello_o = sello_q;
  assign ena_o   = ena_q;

  // R7
  arm_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_flag |=> (arm_q == '0));

endmodule

// File: rtl/irq_flag_cell.sv
module irq_flag_cell
  import irq_flag_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   lvl_i,
  input  logic   prev_i,
  input  sense_e mode_i,
  input  logic   ack_i,
  input  logic   hold_i,
  input  logic   wclr_i,
  output logic   flag_o
);

  logic flag_q, flag_d, flag_en;
  logic set_c, ack_clr;

  always_comb begin
    unique case (mode_i)
      SENSE_LOW:  set_c = !lvl_i;
      SENSE_FALL: set_c = prev_i && !lvl_i;
      SENSE_RISE: set_c = !prev_i && lvl_i;
      default:    set_c = prev_i ^ lvl_i;
    endcase
    ack_clr = ack_i && !hold_i && ((mode_i != SENSE_LOW) || lvl_i);
    flag_en = set_c || ack_clr || wclr_i;
    flag_d  = set_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  // R3 R11
  set_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_c |=> flag_q);

  // R4
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(set_c));

  // R7 R8
  fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(wclr_i || ack_clr));

  // R9
  level_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && ack_i && mode_i == SENSE_LOW && !lvl_i) |=> flag_q);

  // R10
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && hold_i && !wclr_i) |=> flag_q);

endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_flag_pkg::*;
#(
  parameter int NCH         = 8,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_BASE   = 4,
  parameter int NHOLD       = 4,
  localparam int AW         = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pin_i,
  input  logic           bus_rd,
  input  logic           bus_wr,
  input  logic [1:0]     bus_addr,
  input  logic [NCH-1:0] bus_wdata,
  output logic [NCH-1:0] bus_rdata,
  input  logic           ack_valid,
  input  logic [AW-1:0]  ack_chan,
  input  logic [NHOLD-1:0] xfer_hold,
  output logic [NCH-1:0] flag_o,
  output logic           irq_req
);

  logic [NCH-1:0] lvl, prev, selhi, sello, ena, wclr, flags, ack_hit, hold_v;

  irq_pin_sync #(.NCH(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i (pin_i),
    .lvl_o (lvl),
    .prev_o(prev)
  );

  irq_host_regs #(.NCH(NCH)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_i   (bus_rd),
    .wr_i   (bus_wr),
    .addr_i (bus_addr),
    .wdata_i(bus_wdata),
    .flag_i (flags),
    .rdata_o(bus_rdata),
    .selhi_o(selhi),
    .sello_o(sello),
    .ena_o  (ena),
    .wclr_o (wclr)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_cell
    if (c >= HOLD_BASE && c < HOLD_BASE + NHOLD) begin : g_hold
      assign hold_v[c] = xfer_hold[c - HOLD_BASE];
    end else begin : g_nohold
      assign hold_v[c] = 1'b0;
    end

    assign ack_hit[c] = ack_valid && (ack_chan == AW'(c));

    irq_flag_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl_i (lvl[c]),
      .prev_i(prev[c]),
      .mode_i(sense_e'({selhi[c], sello[c]})),
      .ack_i (ack_hit[c]),
      .hold_i(hold_v[c]),
      .wclr_i(wclr[c]),
      .flag_o(flags[c])
    );
  end

  assign flag_o  = flags;
  assign irq_req = |(flags & ena);

endmodule

// File: tb/sim_irq_flag_ctrl.sv
`timescale 1ns/1ps
module sim_irq_flag_ctrl;

  localparam int NCH = 8;
  localparam int LAT = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] pin_i = '1;
  logic           bus_rd = 1'b0, bus_wr = 1'b0;
  logic [1:0]     bus_addr = '0;
  logic [NCH-1:0] bus_wdata = '0;
  logic [NCH-1:0] bus_rdata;
  logic           ack_valid = 1'b0;
  logic [2:0]     ack_chan = '0;
  logic [3:0]     xfer_hold = '0;
  logic [NCH-1:0] flag_o;
  logic           irq_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_flag_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ack_valid(ack_valid), .ack_chan(ack_chan), .xfer_hold(xfer_hold),
    .flag_o(flag_o), .irq_req(irq_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [NCH-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [NCH-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic ack(input int ch);
    @(negedge clk);
    ack_chan = 3'(ch); ack_valid = 1'b1;
    @(negedge clk);
    ack_valid = 1'b0;
  endtask

  task automatic set_pin(input int ch, input logic v);
    @(negedge clk);
    pin_i[ch] = v;
    repeat (LAT) @(negedge clk);
  endtask

  task automatic sw_clear(input int ch);
    logic [NCH-1:0] d;
    bus_read(2'd0, d);
    bus_write(2'd0, ~(NCH'(1) << ch));
  endtask

  task automatic t_reset;
    logic [NCH-1:0] d;
    check("R1 flags", flag_o, 0);
    check("R1 irq_req", irq_req, 0);
    bus_read(2'd1, d); check("R1 selhi", d, 0);
    bus_read(2'd2, d); check("R1 sello", d, 0);
    bus_read(2'd3, d); check("R1 enable", d, 0);
  endtask

  task automatic t_regs;
    logic [NCH-1:0] d;
    // ch0 both(11), ch1 fall(01), ch2 rise(10), ch5 rise(10), ch3 low(00)
    bus_write(2'd1, 8'b0010_0101);
    bus_write(2'd2, 8'b0000_0011);
    bus_read(2'd1, d); check("R2 selhi readback", d, 8'h25);
    bus_read(2'd2, d); check("R2 sello readback", d, 8'h03);
  endtask

  task automatic t_level;
    @(negedge clk); pin_i[3] = 1'b0;
    repeat (LAT - 1) @(negedge clk);
    check("R3 not yet set", flag_o[3], 0);
    @(negedge clk);
    check("R3 low sets", flag_o[3], 1);
    ack(3);
    check("R9 ack while low keeps", flag_o[3], 1);
    set_pin(3, 1'b1);
    check("R3 flag held after high", flag_o[3], 1);
    ack(3);
    check("R9 ack while high clears", flag_o[3], 0);
  endtask

  task automatic t_fall;
    set_pin(1, 1'b0);
    check("R4 falling sets", flag_o[1], 1);
    ack(1);
    check("R8 ack clears edge mode", flag_o[1], 0);
    set_pin(1, 1'b1);
    check("R4 rising ignored", flag_o[1], 0);
  endtask

  task automatic t_rise;
    set_pin(2, 1'b0);
    check("R5 falling ignored", flag_o[2], 0);
    set_pin(2, 1'b1);
    check("R5 rising sets", flag_o[2], 1);
  endtask

  task automatic t_swclear;
    logic [NCH-1:0] d;
    bus_write(2'd0, 8'h00);
    check("R7 write0 without read keeps", flag_o[2], 1);
    bus_read(2'd0, d);
    check("R7 read shows flag", d[2], 1);
    bus_write(2'd0, 8'hFF);
    check("R7 write1 no effect", flag_o[2], 1);
    bus_write(2'd0, 8'h00);
    check("R7 stale read consumed", flag_o[2], 1);
    sw_clear(2);
    check("R7 read1 then write0 clears", flag_o[2], 0);
  endtask

  task automatic t_both;
    logic [NCH-1:0] d;
    set_pin(0, 1'b0);
    check("R6 falling sets", flag_o[0], 1);
    sw_clear(0);
    check("R6 cleared", flag_o[0], 0);
    set_pin(0, 1'b1);
    check("R6 rising sets", flag_o[0], 1);
    // R11: handshake write lands in the cycle the next edge is detected
    bus_read(2'd0, d);
    @(negedge clk); pin_i[0] = 1'b0;
    @(negedge clk);
    @(negedge clk); bus_addr = 2'd0; bus_wdata = 8'hFE; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    check("R11 set wins over clear", flag_o[0], 1);
    sw_clear(0);
    check("R11 later clear works", flag_o[0], 0);
  endtask

  task automatic t_hold;
    @(negedge clk); xfer_hold[1] = 1'b1;
    set_pin(5, 1'b0);
    set_pin(5, 1'b1);
    check("R10 ch5 set", flag_o[5], 1);
    ack(5);
    check("R10 hold blocks ack", flag_o[5], 1);
    sw_clear(5);
    check("R10 software clear under hold", flag_o[5], 0);
    @(negedge clk); xfer_hold[1] = 1'b0;
    set_pin(5, 1'b0);
    set_pin(5, 1'b1);
    ack(5);
    check("R10 ack clears after release", flag_o[5], 0);
  endtask

  task automatic t_req;
    bus_write(2'd3, 8'h04);
    set_pin(3, 1'b0);
    check("R12 masked flag no request", irq_req, 0);
    set_pin(2, 1'b0);
    set_pin(2, 1'b1);
    check("R12 enabled flag requests", irq_req, 1);
    sw_clear(2);
    check("R12 request drops", irq_req, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_level();
    t_fall();
    t_rise();
    t_swclear();
    t_both();
    t_hold();
    t_req();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule